// File: doc/BRIEF.md
# Masked-Compare Repetitive Interrupt Timer

This block is a free-running up counter with a programmable compare value and a per-bit mask. A bit whose mask bit is 1 is left out of the comparison, so one compare value can describe a whole family of counter values (for example every value whose low nibble is zero). On a match the block sets a sticky event flag, which drives the interrupt output as a level. If selected, it also forces the counter back to zero on that same clock edge, which turns the counter into a periodic tick source.

Software reaches four word registers through a simple write-enable, address and data interface. These are the compare value, the mask, a control word and the counter itself. Read data is registered and appears one clock after the address is presented. A halt input stands for a debug break condition. When the control word allows it, the halt input freezes the count.

Top module: `masked_tick_timer`

## Requirements
- R1: After reset the compare and mask registers read 0, the counter reads 0 and starts counting, and the control word reads 0x0C (count enable at bit 3 and break-freeze enable at bit 2 set, bits 1 and 0 clear).
- R2: While counting is allowed, the counter advances by exactly one per clock and passes from all-ones to zero without stopping.
- R3: A match exists when the counter equals the compare value on every bit whose mask bit is 0. Bits with mask 1 always count as equal, so an all-ones mask matches every counter value.
- R4: A match sets the event flag at control bit 0 on the next edge. The flag stays set until software clears it, and the irq output always equals that flag.
- R5: Writing control with bit 0 at 1 clears the flag, and writing bit 0 at 0 leaves it unchanged. A match in the same cycle as a clearing write keeps the flag set.
- R6: With control bit 1 at 1 and counting allowed, a match loads zero into the counter on the edge that sets the flag. With bit 1 at 0, a match leaves the count sequence untouched.
- R7: With control bit 3 at 0 the counter holds its value.
- R8: With control bit 2 at 1, a high halt input freezes the counter even when bit 3 is 1. With bit 2 at 0, halt has no effect.
- R9: A write to the counter register loads any value and takes priority over counting and over clear-on-match in the same cycle.
- R10: The compare register sits at byte offset 0x0, the mask at 0x4, control at 0x8 and the counter at 0xC. Control bits 7:4 are reserved: they ignore writes and, like all higher bits, read as 0. rdata shows the addressed register as it stood at the clock edge that follows the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| halt_in | input | 1 | Debug break condition |
| irq | output | 1 | Level interrupt, equal to the event flag |

## Verification
The bench uses the default parameters: a 32-bit counter and a 4-bit byte address. With the full width in place, the wrap from all-ones to zero cannot be reached by counting up from zero. Software loads of values just below all-ones bring the wrap and the compare across the wrap within a few clocks. The same loads let partial masks, full masks and clear-on-match be tested over short windows of the counter's range.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int CTRL_W = 8;

  // byte offsets of the register file
  localparam int OFS_CMP  = 'h0;
  localparam int OFS_MASK = 'h4;
  localparam int OFS_CTRL = 'h8;
  localparam int OFS_CNT  = 'hC;

  // control bit positions
  localparam int B_FLAG = 0;
  localparam int B_CLR  = 1;
  localparam int B_BRK  = 2;
  localparam int B_EN   = 3;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h0C;
endpackage

// File: rtl/mtt_match.sv
module mtt_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] diff;

  // a bit differs only if it is not masked out
  always_comb diff = (cnt ^ cmp) & ~mask;
  always_comb hit  = (diff == '0);
endmodule

// File: rtl/mtt_ctrl.sv
module mtt_ctrl
  import mtt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [3:0]        wbits,
  input  logic              hit,
  input  logic              halt,
  output logic              run,
  output logic              clr_en,
  output logic              flag,
  output logic [CTRL_W-1:0] rd_val
);
  logic en_q, brk_q, clr_q, flag_q;
  logic clr_req;

  always_comb clr_req = wr && wbits[B_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= CTRL_RESET[B_EN];
      brk_q  <= CTRL_RESET[B_BRK];
      clr_q  <= CTRL_RESET[B_CLR];
      flag_q <= CTRL_RESET[B_FLAG];
    end else begin
      if (wr) begin
        en_q  <= wbits[B_EN];
        brk_q <= wbits[B_BRK];
        clr_q <= wbits[B_CLR];
      end
      // hardware set dominates software clear
      flag_q <= hit || (flag_q && !clr_req);
    end
  end

  always_comb begin
    run    = en_q && !(brk_q && halt);
    clr_en = clr_q;
    flag   = flag_q;
    rd_val = '0;
    rd_val[B_EN]   = en_q;
    rd_val[B_BRK]  = brk_q;
    rd_val[B_CLR]  = clr_q;
    rd_val[B_FLAG] = flag_q;
  end

  // R5: a match on the same edge as a clearing write keeps the flag
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);

  // R4: the flag holds until software clears it
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_req) |=> flag_q);
endmodule

// File: rtl/mtt_counter.sv
module mtt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hit,
  input  logic         clr_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic         wipe;

  always_comb wipe = run && hit && clr_en;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (wipe) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb cnt = cnt_q;

  // R9: a software load lands whatever else happens
  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  // R6: clear-on-match returns the count to zero
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (run && hit && clr_en && !load) |=> (cnt_q == '0));

  // R2: one step per allowed clock, wrapping at the top
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !(hit && clr_en) && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: no count without permission
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/masked_tick_timer.sv
module masked_tick_timer
  import mtt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              halt_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  logic [CNT_W-1:0]  cmp_q, mask_q, cnt;
  logic [CTRL_W-1:0] ctrl_rd;
  logic wr_cmp, wr_mask, wr_ctrl, wr_cnt;
  logic hit, run, clr_en, flag;

  always_comb begin
    wr_cmp  = wr_en && (addr == A_CMP);
    wr_mask = wr_en && (addr == A_MASK);
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_cnt  = wr_en && (addr == A_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cmp)  cmp_q  <= wdata;
      if (wr_mask) mask_q <= wdata;
    end
  end

  mtt_match #(.W(CNT_W)) u_match (
    .cnt (cnt),
    .cmp (cmp_q),
    .mask(mask_q),
    .hit (hit)
  );

  mtt_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_ctrl),
    .wbits (wdata[3:0]),
    .hit   (hit),
    .halt  (halt_in),
    .run   (run),
    .clr_en(clr_en),
    .flag  (flag),
    .rd_val(ctrl_rd)
  );

  mtt_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .hit     (hit),
    .clr_en  (clr_en),
    .load    (wr_cnt),
    .load_val(wdata),
    .cnt     (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CMP:   rdata <= cmp_q;
        A_MASK:  rdata <= mask_q;
        A_CTRL:  rdata <= CNT_W'(ctrl_rd);
        A_CNT:   rdata <= cnt;
        default: rdata <= '0;
      endcase
    end
  end

  always_comb irq = flag;

  // R8: break freeze enabled plus halt keeps the count still
  a_r8_break_freeze: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd[B_BRK] && halt_in && !wr_cnt) |=> $stable(cnt));

  // R3: a full mask matches any counter value
  a_r3_full_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |-> hit);

  // R10: compare register read path
  a_r10_rd_cmp: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CMP) |=> (rdata == $past(cmp_q)));
endmodule

// File: tb/masked_tick_timer_test.sv
`timescale 1ns/1ps
module masked_tick_timer_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          halt_in = 1'b0;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  masked_tick_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .halt_in(halt_in), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] cmp;
    logic [31:0] mask;
    logic [31:0] start;
    logic        clr;
    logic        brk;
    logic        halt;
    logic [7:0]  idle;
    logic [31:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  // each run: counter enabled for idle+1 steps from start (halt permitting)
  localparam vec_t VECS [10] = '{
    '{32'd10,        32'd0,         32'd0,          1'b0, 1'b0, 1'b0, 8'd4,  32'd5,    1'b0},
    '{32'd3,         32'd0,         32'd0,          1'b0, 1'b0, 1'b0, 8'd4,  32'd5,    1'b1},
    '{32'd3,         32'd0,         32'd0,          1'b1, 1'b0, 1'b0, 8'd4,  32'd1,    1'b1},
    '{32'h100,       32'hFFFFFFF0,  32'h25,         1'b0, 1'b0, 1'b0, 8'd10, 32'h30,   1'b1},
    '{32'h7,         32'hFFFFFFF0,  32'h21,         1'b1, 1'b0, 1'b0, 8'd8,  32'd2,    1'b1},
    '{32'd5,         32'd0,         32'hFFFFFFFE,   1'b0, 1'b0, 1'b0, 8'd3,  32'd2,    1'b0},
    '{32'd0,         32'd0,         32'hFFFFFFFE,   1'b0, 1'b0, 1'b0, 8'd3,  32'd2,    1'b1},
    '{32'h1234,      32'hFFFFFFFF,  32'd7,          1'b1, 1'b0, 1'b0, 8'd3,  32'd0,    1'b1},
    '{32'd0,         32'd0,         32'h40,         1'b0, 1'b1, 1'b1, 8'd5,  32'h40,   1'b0},
    '{32'd0,         32'd0,         32'h40,         1'b0, 1'b0, 1'b1, 8'd5,  32'h46,   1'b0}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state; counter 0 at first edge, flag set by 0 == 0 match
    rd(4'hC, v); check("R1 counter", v, 32'd0);
    rd(4'h8, v); check("R1 control (flag from match R4)", v, 32'h0D);
    rd(4'h0, v); check("R1 compare", v, 32'd0);
    rd(4'h4, v); check("R1 mask", v, 32'd0);
    check("R4 irq level", {31'd0, irq}, 32'd1);

    // table walk: R2 R3 R6 R7 R8 R9
    foreach (VECS[i]) begin
      halt_in = VECS[i].halt;
      wr(4'h8, 32'h0);
      wr(4'h0, VECS[i].cmp);
      wr(4'h4, VECS[i].mask);
      wr(4'hC, VECS[i].start);
      wr(4'h8, {28'd0, 1'b1, VECS[i].brk, VECS[i].clr, 1'b1});
      repeat (int'(VECS[i].idle)) @(negedge clk);
      wr(4'h8, 32'h0);
      rd(4'hC, v);
      check($sformatf("R2/R3/R6/R8/R9 vector %0d count", i), v, VECS[i].exp_cnt);
      rd(4'h8, v);
      check($sformatf("R3/R4 vector %0d flag", i), v, {31'd0, VECS[i].exp_flag});
      halt_in = 1'b0;
    end

    // R5 set wins over clear; writing 0 leaves flag
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h77);
    wr(4'h4, 32'h0);
    wr(4'hC, 32'h77);
    wr(4'h8, 32'h1);
    rd(4'h8, v); check("R5 set wins over clear", v, 32'h1);
    wr(4'h0, 32'h78);
    wr(4'h8, 32'h1);
    rd(4'h8, v); check("R5 clear by writing 1", v, 32'h0);
    check("R4 irq follows clear", {31'd0, irq}, 32'd0);
    wr(4'h0, 32'h77);
    wr(4'h0, 32'h99);
    wr(4'h8, 32'h0);
    rd(4'h8, v); check("R5 writing 0 keeps flag", v, 32'h1);
    check("R4 irq held", {31'd0, irq}, 32'd1);

    // R9 load beats clear-on-match and counting
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h50);
    wr(4'hC, 32'h50);
    wr(4'h8, 32'hB);
    wr(4'hC, 32'h1234);
    rd(4'hC, v); check("R9 load priority", v, 32'h1234);
    rd(4'hC, v); check("R2 counts on after load", v, 32'h1235);

    // R10 reserved control bits, R7 hold when disabled
    wr(4'h8, 32'hF5);
    rd(4'h8, v); check("R10 reserved bits read zero", v, 32'h04);
    rd(4'hC, v);
    rd(4'hC, v2); check("R7 counter holds while disabled", v2, v);
    wr(4'h4, 32'hA5A5_0F0F);
    rd(4'h4, v); check("R10 mask readback", v, 32'hA5A5_0F0F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule